// File: doc/BRIEF.md
# Timer Control and Status Register Block

This block holds the two configuration and status words of a processor timer unit: a 32-bit control word that software loads directly, and a 32-bit status word whose event bits are set by strobes from the decrementer, the fixed-interval timer and the watchdog. Software acknowledges an event by writing a one to its status bit. Writing a zero to a bit leaves it as it was.

The block combines each sticky status bit with its enable bit and drives a registered level interrupt for each of the three timers. It decodes the period fields into a time-base bit index for the fixed-interval and watchdog engines. It also passes the auto-reload enable and the watchdog reset control field to those engines. When software acknowledges a fixed-interval or watchdog event, the block sends that engine a one-cycle re-arm pulse, so the engine starts waiting for its next period.

A run-resume input discards any watchdog state that built up while the processor was halted. The parameter `EXT_MODE` selects how the period fields are decoded. With it set, the 2-bit periods are widened by 4-bit extension fields. With it clear, a fixed base-plus-step mapping is used.

Top module: `timer_ctrl_regs`

## Requirements
- R1: After reset the control word, the status word, all three interrupt outputs and both re-arm outputs are 0.
- R2: A control write stores bits 31:22, plus bits 20:13 when `EXT_MODE`=1. Every other control bit reads 0.
- R3: The watchdog period selector is control bits 31:30 and its extension is bits 20:17. The fixed-interval selector is bits 25:24 and its extension is bits 16:13. With `EXT_MODE`=1 each target bit index is 63-(sel | ext<<2). With `EXT_MODE`=0 it is base+4*sel, where the base is 21 for the watchdog and 9 for the fixed-interval timer. `auto_reload_o` follows control bit 22 and `wdt_rst_ctl_o` follows bits 29:28.
- R4: Each hardware strobe sets a status bit one cycle after it is applied, and the bit stays set after the strobe ends. The mapping is: decrementer to bit 27, fixed-interval to bit 26, watchdog to bit 30, next-watchdog enable to bit 31, and watchdog reset status OR-ed into bits 29:28. All other status bits read 0.
- R5: A status write clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R6: When a hardware set and a software clear or run-resume clear hit the same bit in the same cycle, the bit ends up set.
- R7: Each interrupt output equals the AND of its status bit and its enable bit, one cycle after those bits change. The pairs are: decrementer, status 27 with control 26; watchdog, status 30 with control 27; fixed-interval, status 26 with control 23.
- R8: A run-resume pulse clears status bits 31:28 and leaves bits 27 and 26 unchanged.
- R9: A status write with bit 26 (or bit 30) set gives exactly one cycle of `fit_rearm_o` (or `wdt_rearm_o`) in the next cycle. A write with that bit at 0 gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word write data |
| sts_we_i | input | 1 | Status write strobe (write one to clear) |
| sts_wdata_i | input | 32 | Status clear mask |
| dec_evt_i | input | 1 | Decrementer expiry strobe |
| fit_evt_i | input | 1 | Fixed-interval expiry strobe |
| wdt_evt_i | input | 1 | Watchdog expiry strobe |
| enw_set_i | input | 1 | Sets next-watchdog enable status |
| wrs_set_i | input | 2 | OR-set into watchdog reset status |
| resume_i | input | 1 | Run-resume pulse |
| ctl_o | output | 32 | Control word |
| sts_o | output | 32 | Status word |
| dec_irq_o | output | 1 | Decrementer interrupt |
| fit_irq_o | output | 1 | Fixed-interval interrupt |
| wdt_irq_o | output | 1 | Watchdog interrupt |
| fit_rearm_o | output | 1 | Fixed-interval re-arm pulse |
| wdt_rearm_o | output | 1 | Watchdog re-arm pulse |
| fit_tgt_o | output | 6 | Fixed-interval target time-base bit |
| wdt_tgt_o | output | 6 | Watchdog target time-base bit |
| wdt_rst_ctl_o | output | 2 | Watchdog reset control field |
| auto_reload_o | output | 1 | Decrementer auto-reload enable |

## Verification
The bench sweeps all 64 selector and extension pairs through both decode variants. An off-by-one shift or a swapped field would put an engine's target on the wrong time-base bit. For each interrupt it walks every status and enable combination and samples exactly one cycle after the change. A combinational path would show up a cycle early, and a crossed enable would light the wrong interrupt. It drives a strobe and a clear-all write in the same cycle, and a strobe together with run-resume. A design that lets the clear win would lose the event. Run-resume must leave the decrementer and fixed-interval bits alone, and the re-arm pulse must last one cycle and follow only writes of one.

// File: rtl/timer_regs_pkg.sv
package timer_regs_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned TGT_W  = 6;

  // control word bit positions (decoded by timer engines)
  localparam int unsigned C_WP_LO   = 30;
  localparam int unsigned C_WRC_LO  = 28;
  localparam int unsigned C_WIE     = 27;
  localparam int unsigned C_DIE     = 26;
  localparam int unsigned C_FP_LO   = 24;
  localparam int unsigned C_FIE     = 23;
  localparam int unsigned C_ARE     = 22;
  localparam int unsigned C_WPX_LO  = 17;
  localparam int unsigned C_FPX_LO  = 13;

  // status word bit positions
  localparam int unsigned S_ENW     = 31;
  localparam int unsigned S_WIS     = 30;
  localparam int unsigned S_WRS_LO  = 28;
  localparam int unsigned S_DIS     = 27;
  localparam int unsigned S_FIS     = 26;

  localparam logic [WORD_W-1:0] CTL_MASK_BASE = 32'hFFC0_0000;
  localparam logic [WORD_W-1:0] CTL_MASK_EXT  = 32'h001F_E000;
  localparam logic [WORD_W-1:0] STS_MASK      = 32'hFC00_0000;
  localparam logic [WORD_W-1:0] RESUME_MASK   = 32'hF000_0000;

  typedef struct packed {
    logic [1:0] wdt_sel;
    logic [3:0] wdt_ext;
    logic [1:0] fit_sel;
    logic [3:0] fit_ext;
    logic [1:0] wdt_rst_ctl;
    logic       wdt_ie;
    logic       dec_ie;
    logic       fit_ie;
    logic       auto_reload;
  } ctl_fields_t;

  typedef struct packed {
    logic dec;
    logic fit;
    logic wdt;
  } irq_vec_t;
endpackage

// File: rtl/tcr_reg.sv
module tcr_reg
  import timer_regs_pkg::*;
#(
  parameter bit EXT_MODE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] ctl_o,
  output ctl_fields_t       fld_o
);
  localparam logic [WORD_W-1:0] CtlMask =
    EXT_MODE ? (CTL_MASK_BASE | CTL_MASK_EXT) : CTL_MASK_BASE;

  logic [WORD_W-1:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else if (we_i) ctl_q <= wdata_i & CtlMask;
  end

  assign ctl_o = ctl_q;

  always_comb begin
    fld_o             = '0;
    fld_o.wdt_sel     = ctl_q[C_WP_LO +: 2];
    fld_o.wdt_ext     = ctl_q[C_WPX_LO +: 4];
    fld_o.fit_sel     = ctl_q[C_FP_LO +: 2];
    fld_o.fit_ext     = ctl_q[C_FPX_LO +: 4];
    fld_o.wdt_rst_ctl = ctl_q[C_WRC_LO +: 2];
    fld_o.wdt_ie      = ctl_q[C_WIE];
    fld_o.dec_ie      = ctl_q[C_DIE];
    fld_o.fit_ie      = ctl_q[C_FIE];
    fld_o.auto_reload = ctl_q[C_ARE];
  end
endmodule

// File: rtl/period_dec.sv
module period_dec
  import timer_regs_pkg::*;
#(
  parameter bit          EXT_MODE = 1'b1,
  parameter int unsigned BASE     = 21
) (
  input  logic [1:0]       sel_i,
  input  logic [3:0]       ext_i,
  output logic [TGT_W-1:0] tgt_o
);
  localparam int unsigned TopBit = (1 << TGT_W) - 1;

  generate
    if (EXT_MODE) begin : g_ext
      logic [TGT_W-1:0] code;
      assign code  = {ext_i, sel_i};
      assign tgt_o = TGT_W'(TopBit) - code;
    end else begin : g_fix
      logic [TGT_W-1:0] unused_ext;
      assign unused_ext = TGT_W'(ext_i);
      assign tgt_o = TGT_W'(BASE) + {2'b00, sel_i, 2'b00};
    end
  endgenerate
endmodule

// File: rtl/tsr_reg.sv
module tsr_reg
  import timer_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              dec_evt_i,
  input  logic              fit_evt_i,
  input  logic              wdt_evt_i,
  input  logic              enw_set_i,
  input  logic [1:0]        wrs_set_i,
  input  logic              resume_i,
  output logic [WORD_W-1:0] sts_o,
  output logic              fit_rearm_o,
  output logic              wdt_rearm_o
);
  logic [WORD_W-1:0] sts_q, clr, set, sts_d;
  logic              fit_rearm_q, wdt_rearm_q;

  always_comb begin
    clr = '0;
    if (we_i)     clr = clr | wdata_i;
    if (resume_i) clr = clr | RESUME_MASK;
    set = '0;
    set[S_DIS]         = dec_evt_i;
    set[S_FIS]         = fit_evt_i;
    set[S_WIS]         = wdt_evt_i;
    set[S_ENW]         = enw_set_i;
    set[S_WRS_LO +: 2] = wrs_set_i;
    // set has priority over any clear source
    sts_d = ((sts_q & ~clr) | set) & STS_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q       <= '0;
      fit_rearm_q <= 1'b0;
      wdt_rearm_q <= 1'b0;
    end else begin
      sts_q       <= sts_d;
      fit_rearm_q <= we_i & wdata_i[S_FIS];
      wdt_rearm_q <= we_i & wdata_i[S_WIS];
    end
  end

  assign sts_o       = sts_q;
  assign fit_rearm_o = fit_rearm_q;
  assign wdt_rearm_o = wdt_rearm_q;
endmodule

// File: rtl/irq_gen.sv
module irq_gen
  import timer_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] sts_i,
  input  ctl_fields_t       fld_i,
  output irq_vec_t          irq_o
);
  irq_vec_t irq_q, irq_d;

  always_comb begin
    irq_d.dec = sts_i[S_DIS] & fld_i.dec_ie;
    irq_d.fit = sts_i[S_FIS] & fld_i.fit_ie;
    irq_d.wdt = sts_i[S_WIS] & fld_i.wdt_ie;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/timer_ctrl_regs.sv
module timer_ctrl_regs
  import timer_regs_pkg::*;
#(
  parameter bit          EXT_MODE = 1'b1,
  parameter int unsigned WDT_BASE = 21,
  parameter int unsigned FIT_BASE = 9
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctl_we_i,
  input  logic [31:0] ctl_wdata_i,
  input  logic        sts_we_i,
  input  logic [31:0] sts_wdata_i,
  input  logic        dec_evt_i,
  input  logic        fit_evt_i,
  input  logic        wdt_evt_i,
  input  logic        enw_set_i,
  input  logic [1:0]  wrs_set_i,
  input  logic        resume_i,
  output logic [31:0] ctl_o,
  output logic [31:0] sts_o,
  output logic        dec_irq_o,
  output logic        fit_irq_o,
  output logic        wdt_irq_o,
  output logic        fit_rearm_o,
  output logic        wdt_rearm_o,
  output logic [5:0]  fit_tgt_o,
  output logic [5:0]  wdt_tgt_o,
  output logic [1:0]  wdt_rst_ctl_o,
  output logic        auto_reload_o
);
  ctl_fields_t fld;
  irq_vec_t    irq;

  tcr_reg #(.EXT_MODE(EXT_MODE)) i_tcr (
    .clk_i, .rst_ni, .we_i(ctl_we_i), .wdata_i(ctl_wdata_i),
    .ctl_o, .fld_o(fld)
  );

  tsr_reg i_tsr (
    .clk_i, .rst_ni, .we_i(sts_we_i), .wdata_i(sts_wdata_i),
    .dec_evt_i, .fit_evt_i, .wdt_evt_i, .enw_set_i, .wrs_set_i, .resume_i,
    .sts_o, .fit_rearm_o, .wdt_rearm_o
  );

  period_dec #(.EXT_MODE(EXT_MODE), .BASE(WDT_BASE)) i_wdt_dec (
    .sel_i(fld.wdt_sel), .ext_i(fld.wdt_ext), .tgt_o(wdt_tgt_o)
  );

  period_dec #(.EXT_MODE(EXT_MODE), .BASE(FIT_BASE)) i_fit_dec (
    .sel_i(fld.fit_sel), .ext_i(fld.fit_ext), .tgt_o(fit_tgt_o)
  );

  irq_gen i_irq (
    .clk_i, .rst_ni, .sts_i(sts_o), .fld_i(fld), .irq_o(irq)
  );

  assign dec_irq_o     = irq.dec;
  assign fit_irq_o     = irq.fit;
  assign wdt_irq_o     = irq.wdt;
  assign wdt_rst_ctl_o = fld.wdt_rst_ctl;
  assign auto_reload_o = fld.auto_reload;
endmodule

// File: rtl/timer_ctrl_regs_chk.sv
module timer_ctrl_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctl_we_i,
  input logic [31:0] ctl_wdata_i,
  input logic        sts_we_i,
  input logic [31:0] sts_wdata_i,
  input logic        dec_evt_i,
  input logic        fit_evt_i,
  input logic        wdt_evt_i,
  input logic        enw_set_i,
  input logic [1:0]  wrs_set_i,
  input logic        resume_i,
  input logic [31:0] ctl_o,
  input logic [31:0] sts_o,
  input logic        dec_irq_o,
  input logic        fit_irq_o,
  input logic        wdt_irq_o,
  input logic        fit_rearm_o,
  input logic        wdt_rearm_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_EVT_SETS_WDT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_evt_i |=> sts_o[30]); // R6
  AST_W1C_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_we_i && sts_wdata_i[27] && !dec_evt_i) |=> !sts_o[27]); // R5
  AST_RESUME_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_i && !wdt_evt_i) |=> !sts_o[30]); // R8
  AST_DEC_IRQ_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> dec_irq_o == $past(sts_o[27] && ctl_o[26])); // R7
  AST_WDT_IRQ_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> wdt_irq_o == $past(sts_o[30] && ctl_o[27])); // R7
  AST_FIT_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> fit_rearm_o == $past(sts_we_i && sts_wdata_i[26])); // R9
  AST_STS_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o[25:0] == 26'd0); // R4
  AST_STICKY_FIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o[26] && !sts_we_i) |=> sts_o[26]); // R4
endmodule

bind timer_ctrl_regs timer_ctrl_regs_chk i_chk (.*);

// File: tb/test_timer_ctrl_regs.sv
`timescale 1ns/1ps
module test_timer_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctl_we = 1'b0, sts_we = 1'b0;
  logic [31:0] ctl_wdata = '0, sts_wdata = '0;
  logic        dec_evt = 1'b0, fit_evt = 1'b0, wdt_evt = 1'b0, enw_set = 1'b0;
  logic [1:0]  wrs_set = '0;
  logic        resume = 1'b0;

  logic [31:0] ctl, sts, ctl_c, sts_c;
  logic        dec_irq, fit_irq, wdt_irq, fit_rearm, wdt_rearm;
  logic [5:0]  fit_tgt, wdt_tgt, fit_tgt_c, wdt_tgt_c;
  logic [1:0]  wrc, wrc_c;
  logic        are, are_c;
  logic        d0, d1, d2, d3, d4;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  timer_ctrl_regs #(.EXT_MODE(1'b1)) i_timer_ctrl_regs (
    .clk_i(clk), .rst_ni, .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .sts_we_i(sts_we), .sts_wdata_i(sts_wdata), .dec_evt_i(dec_evt),
    .fit_evt_i(fit_evt), .wdt_evt_i(wdt_evt), .enw_set_i(enw_set),
    .wrs_set_i(wrs_set), .resume_i(resume), .ctl_o(ctl), .sts_o(sts),
    .dec_irq_o(dec_irq), .fit_irq_o(fit_irq), .wdt_irq_o(wdt_irq),
    .fit_rearm_o(fit_rearm), .wdt_rearm_o(wdt_rearm), .fit_tgt_o(fit_tgt),
    .wdt_tgt_o(wdt_tgt), .wdt_rst_ctl_o(wrc), .auto_reload_o(are)
  );

  timer_ctrl_regs #(.EXT_MODE(1'b0)) i_timer_ctrl_regs_fix (
    .clk_i(clk), .rst_ni, .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .sts_we_i(sts_we), .sts_wdata_i(sts_wdata), .dec_evt_i(dec_evt),
    .fit_evt_i(fit_evt), .wdt_evt_i(wdt_evt), .enw_set_i(enw_set),
    .wrs_set_i(wrs_set), .resume_i(resume), .ctl_o(ctl_c), .sts_o(sts_c),
    .dec_irq_o(d0), .fit_irq_o(d1), .wdt_irq_o(d2),
    .fit_rearm_o(d3), .wdt_rearm_o(d4), .fit_tgt_o(fit_tgt_c),
    .wdt_tgt_o(wdt_tgt_c), .wdt_rst_ctl_o(wrc_c), .auto_reload_o(are_c)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ctl_we = 0; sts_we = 0; dec_evt = 0; fit_evt = 0; wdt_evt = 0;
    enw_set = 0; wrs_set = '0; resume = 0;
  endtask

  // inputs applied at a negedge, captured at the next posedge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic wr_ctl(input logic [31:0] v);
    ctl_we = 1; ctl_wdata = v; step();
  endtask

  task automatic wr_sts(input logic [31:0] v);
    sts_we = 1; sts_wdata = v; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 ctl", ctl, 0);
    chk("R1 sts", sts, 0);
    chk("R1 irq/rearm", {27'd0, dec_irq, fit_irq, wdt_irq, fit_rearm, wdt_rearm}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 stored bits per mode
    wr_ctl(32'hFFFF_FFFF);
    chk("R2 ext mask", ctl, 32'hFFDF_E000);
    chk("R2 fixed mask", ctl_c, 32'hFFC0_0000);
    chk("R3 auto_reload", {31'd0, are}, 1);
    chk("R3 wdt_rst_ctl", {30'd0, wrc}, 3);
    wr_ctl(32'h1000_0000);
    chk("R3 wdt_rst_ctl 1", {30'd0, wrc}, 1);
    chk("R3 auto_reload 0", {31'd0, are}, 0);

    // R3 exhaustive period decode, both variants
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 16; e++) begin
        wr_ctl((32'(s) << 30) | (32'(e) << 17) | (32'(s) << 24) | (32'(e) << 13));
        chk("R3 wdt ext tgt", {26'd0, wdt_tgt}, 32'(63 - (s | (e << 2))));
        chk("R3 fit ext tgt", {26'd0, fit_tgt}, 32'(63 - (s | (e << 2))));
        chk("R3 wdt fix tgt", {26'd0, wdt_tgt_c}, 32'(21 + 4 * s));
        chk("R3 fit fix tgt", {26'd0, fit_tgt_c}, 32'(9 + 4 * s));
      end
    end

    // R4 / R7 each source over enable on/off
    for (int src = 0; src < 3; src++) begin
      for (int en = 0; en < 2; en++) begin
        logic [31:0] en_bit, st_bit;
        en_bit = (src == 0) ? 32'h0400_0000 : (src == 1) ? 32'h0080_0000 : 32'h0800_0000;
        st_bit = (src == 0) ? 32'h0800_0000 : (src == 1) ? 32'h0400_0000 : 32'h4000_0000;
        wr_ctl(en ? en_bit : 32'h0);
        dec_evt = (src == 0); fit_evt = (src == 1); wdt_evt = (src == 2);
        step();
        chk("R4 event sets bit", sts, st_bit);
        chk("R7 irq lags one cycle", {29'd0, dec_irq, fit_irq, wdt_irq}, 0);
        @(negedge clk);
        chk("R4 sticky", sts, st_bit);
        chk("R7 irq = sts & en",
            {29'd0, dec_irq, fit_irq, wdt_irq},
            en ? ((src == 0) ? 4 : (src == 1) ? 2 : 1) : 0);
        wr_sts(32'hFFFF_FFFF);
        chk("R5 clear all", sts, 0);
        @(negedge clk);
        chk("R7 irq drops", {29'd0, dec_irq, fit_irq, wdt_irq}, 0);
      end
    end

    // R7 enable toggled while status held
    wr_ctl(32'h0);
    dec_evt = 1; step();
    wr_ctl(32'h0400_0000);
    chk("R7 enable change lag", {31'd0, dec_irq}, 0);
    @(negedge clk);
    chk("R7 enable change", {31'd0, dec_irq}, 1);
    wr_ctl(32'h0);
    @(negedge clk);
    chk("R7 enable off", {31'd0, dec_irq}, 0);

    // R4 enw/wrs, R5 selective clear
    enw_set = 1; wrs_set = 2'b01; fit_evt = 1; dec_evt = 1; step();
    wrs_set = 2'b10; step();
    chk("R4 enw/wrs set", sts, 32'hBC00_0000);
    wr_sts(32'h2000_0000 | 32'h0400_0000);
    chk("R5 selective clear", sts, 32'h9800_0000);
    wr_sts(32'h0);
    chk("R5 zero write no effect", sts, 32'h9800_0000);

    // R8 resume
    wdt_evt = 1; wrs_set = 2'b11; fit_evt = 1; step();
    chk("R8 pre-resume", sts, 32'hFC00_0000);
    resume = 1; step();
    chk("R8 resume clears watchdog state", sts, 32'h0C00_0000);

    // R6 set wins
    sts_we = 1; sts_wdata = 32'hFFFF_FFFF; dec_evt = 1; step();
    chk("R6 set beats write clear", sts, 32'h0800_0000);
    resume = 1; wdt_evt = 1; step();
    chk("R6 set beats resume", sts, 32'h4800_0000);
    wr_sts(32'hFFFF_FFFF);

    // R9 re-arm pulses
    wr_sts(32'h0400_0000);
    chk("R9 fit rearm", {30'd0, fit_rearm, wdt_rearm}, 2);
    @(negedge clk);
    chk("R9 fit rearm single", {30'd0, fit_rearm, wdt_rearm}, 0);
    wr_sts(32'h4000_0000);
    chk("R9 wdt rearm", {30'd0, fit_rearm, wdt_rearm}, 1);
    @(negedge clk);
    chk("R9 wdt rearm single", {30'd0, fit_rearm, wdt_rearm}, 0);
    wr_sts(32'hBBFF_FFFF);
    chk("R9 no rearm on zero", {30'd0, fit_rearm, wdt_rearm}, 0);
    resume = 1; step();
    chk("R9 resume no rearm", {30'd0, fit_rearm, wdt_rearm}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule